// File: doc/BRIEF.md
# Serial Port Modem Control and Diagnostic Loopback

This block holds the modem control byte of a 16550-style serial port and routes the port's serial and modem signals from it. The CPU writes a five-bit control field. Two of those bits drive the active-low data-terminal-ready and request-to-send pins. One bit is a general-purpose flag with no pin, which only the CPU reads and writes. One bit decides whether the serial interrupt line is driven or left at high impedance. The last bit selects a diagnostic loopback mode.

In loopback mode the transmit line is parked at the marking level, and the external receive line is cut off from the receiver. The transmit shift register's output is fed straight back into the receive shift register's input. The four control bits stand in for the four external modem status inputs, and the two modem output pins are forced to their inactive level. The modem status outputs of this block feed the port's modem status interrupt logic. That logic, with its own enable register, lies outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset every control bit is 0. As a result dtr_n and rts_n are 1, irq_oe is 0, loopback is off and cpu_rdata is 0.
- R2: A write strobe stores cpu_wdata[4:0] on the clock edge. A read strobe loads the stored byte into cpu_rdata on the next clock edge, so a read in the same cycle as a write returns the old value. cpu_rdata bits 7 to 5 always read 0.
- R3: Outside loopback, dtr_n is the inverse of bit 0 and rts_n is the inverse of bit 1. Writing a 1 drives the pin low.
- R4: Bit 2 drives no pin. It is only observable through cpu_rdata and, in loopback, through ri.
- R5: irq_oe equals bit 3. While irq_oe is 1, irq_out follows irq_req. While irq_oe is 0, irq_out is high impedance.
- R6: With bit 4 set, txd_pin is 1, rx_shift_in equals tx_shift_out, and rxd_pin has no effect.
- R7: With bit 4 set, dtr_n and rts_n are both 1 whatever bits 0 and 1 hold.
- R8: With bit 4 set, the external status pins have no effect. dsr equals bit 0, cts equals bit 1, ri equals bit 2 and dcd equals bit 3.
- R9: Outside loopback, txd_pin equals tx_shift_out and rx_shift_in equals rxd_pin. cts, dsr, ri and dcd are the inverses of cts_n_pin, dsr_n_pin, ri_n_pin and dcd_n_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered on a read strobe |
| tx_shift_out | input | 1 | Serial bit from the transmit shift register |
| rx_shift_in | output | 1 | Serial bit to the receive shift register |
| txd_pin | output | 1 | Transmit line pin |
| rxd_pin | input | 1 | Receive line pin |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| cts_n_pin | input | 1 | Clear to send pin, active low |
| dsr_n_pin | input | 1 | Data set ready pin, active low |
| ri_n_pin | input | 1 | Ring indicator pin, active low |
| dcd_n_pin | input | 1 | Carrier detect pin, active low |
| cts | output | 1 | Clear-to-send status, active high |
| dsr | output | 1 | Data-set-ready status, active high |
| ri | output | 1 | Ring status, active high |
| dcd | output | 1 | Carrier status, active high |
| irq_req | input | 1 | Interrupt request from the port's interrupt logic |
| irq_out | output | 1 | Serial interrupt line, high impedance when disabled |
| irq_oe | output | 1 | Drive enable of irq_out |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any strobe. They also assume that every input changes only between clock edges, so the combinational routing is stable when sampled. The bench drives every input at the falling edge, randomises the strobes, data, serial bit and status pins there, and samples the outputs at the same falling edge before it applies the new values. The high-impedance level of irq_out is not compared. While irq_oe is 0, the bench checks only irq_oe.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W    = 8;
  localparam int CTL_W    = 5;
  localparam int LINES    = 4;
  localparam int PIN_OUTS = 2;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctl_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
  parameter int REG_W = 8,
  parameter int CTL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] KEEP = REG_W'((1 << CTL_W) - 1);

  logic [REG_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr) byte_q <= wdata & KEEP;
      if (rd) rdata  <= byte_q;
    end
  end

  assign ctl = byte_q[CTL_W-1:0];

  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctl == $past(wdata[CTL_W-1:0])); // R2
  AST_RD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> rdata[CTL_W-1:0] == $past(ctl)); // R2
endmodule

// File: rtl/mdm_serial_path.sv
module mdm_serial_path (
  input  logic loop,
  input  logic tx_bit,
  input  logic rxd_pin,
  output logic txd_pin,
  output logic rx_bit
);
  assign txd_pin = loop ? 1'b1 : tx_bit;
  assign rx_bit  = loop ? tx_bit : rxd_pin;
endmodule

// File: rtl/mdm_status_map.sv
module mdm_status_map #(
  parameter int LINES    = 4,
  parameter int PIN_OUTS = 2
) (
  input  logic                loop,
  input  logic [LINES-1:0]    ctl_lines,
  input  logic [LINES-1:0]    in_n,
  output logic [LINES-1:0]    status,
  output logic [PIN_OUTS-1:0] out_n
);
  for (genvar i = 0; i < LINES; i++) begin : g_stat
    assign status[i] = loop ? ctl_lines[i] : ~in_n[i];
  end
  for (genvar j = 0; j < PIN_OUTS; j++) begin : g_pin
    assign out_n[j] = loop | ~ctl_lines[j];
  end
endmodule

// File: rtl/mdm_irq_gate.sv
module mdm_irq_gate (
  input  logic en,
  input  logic req,
  output logic oe,
  output logic line
);
  assign oe   = en;
  assign line = en ? req : 1'bz;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             tx_shift_out,
  output logic             rx_shift_in,
  output logic             txd_pin,
  input  logic             rxd_pin,
  output logic             dtr_n,
  output logic             rts_n,
  input  logic             cts_n_pin,
  input  logic             dsr_n_pin,
  input  logic             ri_n_pin,
  input  logic             dcd_n_pin,
  output logic             cts,
  output logic             dsr,
  output logic             ri,
  output logic             dcd,
  input  logic             irq_req,
  output logic             irq_out,
  output logic             irq_oe
);
  ctl_t                ctl;
  logic [CTL_W-1:0]    ctl_bits;
  logic [LINES-1:0]    in_n;
  logic [LINES-1:0]    status;
  logic [PIN_OUTS-1:0] out_n;

  mdm_ctl_reg #(.REG_W(REG_W), .CTL_W(CTL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd),
    .wdata(cpu_wdata), .ctl(ctl_bits), .rdata(cpu_rdata)
  );
  assign ctl = ctl_t'(ctl_bits);

  mdm_serial_path u_ser (
    .loop(ctl.loop), .tx_bit(tx_shift_out), .rxd_pin(rxd_pin),
    .txd_pin(txd_pin), .rx_bit(rx_shift_in)
  );

  // line order: 0 dtr->dsr, 1 rts->cts, 2 out1->ri, 3 out2->dcd
  assign in_n = {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin};

  mdm_status_map #(.LINES(LINES), .PIN_OUTS(PIN_OUTS)) u_map (
    .loop(ctl.loop), .ctl_lines(ctl_bits[LINES-1:0]), .in_n(in_n),
    .status(status), .out_n(out_n)
  );
  assign dsr   = status[0];
  assign cts   = status[1];
  assign ri    = status[2];
  assign dcd   = status[3];
  assign dtr_n = out_n[0];
  assign rts_n = out_n[1];

  mdm_irq_gate u_irq (
    .en(ctl.out2), .req(irq_req), .oe(irq_oe), .line(irq_out)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[REG_W-1:CTL_W] == '0); // R2
  AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loop |-> (dtr_n == !ctl.dtr) && (rts_n == !ctl.rts)); // R3
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> irq_out == irq_req); // R5
  AST_TXD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loop |-> txd_pin && (rx_shift_in == tx_shift_out)); // R6
  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loop |-> dtr_n && rts_n); // R7
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loop |-> {dcd, ri, cts, dsr} == {ctl.out2, ctl.out1, ctl.rts, ctl.dtr}); // R8
  AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loop |-> (txd_pin == tx_shift_out) && (rx_shift_in == rxd_pin)); // R9
endmodule

// File: tb/uart_modem_ctl_test.sv
module uart_modem_ctl_test;
  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic tx_shift_out = 0, rx_shift_in, txd_pin, rxd_pin = 0;
  logic dtr_n, rts_n, cts, dsr, ri, dcd;
  logic cts_n_pin = 1, dsr_n_pin = 1, ri_n_pin = 1, dcd_n_pin = 1;
  logic irq_req = 0, irq_out, irq_oe;

  int checks = 0, fails = 0;
  int m_reg = 0, m_rd = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_modem_ctl uut (.*);

  // behavioural reference: stored byte and read-back latch
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg <= 0; m_rd <= 0;
    end else begin
      if (cpu_wr) m_reg <= cpu_wdata % 32;
      if (cpu_rd) m_rd <= m_reg;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    bit lp = (m_reg / 16) % 2 == 1;
    int b0 = m_reg % 2, b1 = (m_reg / 2) % 2, b2 = (m_reg / 4) % 2, b3 = (m_reg / 8) % 2;
    chk("R2 rdata", int'(cpu_rdata), m_rd);
    chk("R5 irq_oe", int'(irq_oe), b3);
    if (b3 == 1) chk("R5 irq_out", int'(irq_out), int'(irq_req));
    if (lp) begin
      chk("R6 txd", int'(txd_pin), 1);
      chk("R6 rx", int'(rx_shift_in), int'(tx_shift_out));
      chk("R7 dtr_n", int'(dtr_n), 1);
      chk("R7 rts_n", int'(rts_n), 1);
      chk("R8 dsr", int'(dsr), b0);
      chk("R8 cts", int'(cts), b1);
      chk("R8 ri R4", int'(ri), b2);
      chk("R8 dcd", int'(dcd), b3);
    end else begin
      chk("R3 dtr_n", int'(dtr_n), 1 - b0);
      chk("R3 rts_n", int'(rts_n), 1 - b1);
      chk("R9 txd", int'(txd_pin), int'(tx_shift_out));
      chk("R9 rx", int'(rx_shift_in), int'(rxd_pin));
      chk("R9 dsr", int'(dsr), int'(!dsr_n_pin));
      chk("R9 cts", int'(cts), int'(!cts_n_pin));
      chk("R9 ri", int'(ri), int'(!ri_n_pin));
      chk("R9 dcd", int'(dcd), int'(!dcd_n_pin));
    end
  endtask

  task automatic step(bit wr, bit rd, logic [7:0] d);
    @(negedge clk);
    compare_all();
    cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
    tx_shift_out = 1'($urandom); rxd_pin = 1'($urandom); irq_req = 1'($urandom);
    {cts_n_pin, dsr_n_pin, ri_n_pin, dcd_n_pin} = 4'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dtr_n", int'(dtr_n), 1);
    chk("R1 rts_n", int'(rts_n), 1);
    chk("R1 irq_oe", int'(irq_oe), 0);
    chk("R1 rdata", int'(cpu_rdata), 0);
    chk("R1 txd", int'(txd_pin), int'(tx_shift_out));
    // directed: each bit alone, reserved bits set, read-back
    step(1, 0, 8'hE1); step(0, 1, 0); step(0, 0, 0);
    step(1, 1, 8'h02); step(0, 1, 0); step(0, 0, 0);
    step(1, 0, 8'h04); step(0, 1, 0); step(0, 0, 0);   // R4 OUT1 only via read
    step(1, 0, 8'h08); step(0, 1, 0); step(0, 0, 0);
    step(1, 0, 8'h1F); step(0, 1, 0); step(0, 0, 0);   // loopback with all bits
    step(1, 0, 8'h10); step(0, 1, 0); step(0, 0, 0);   // loopback, bits clear
    step(1, 0, 8'h03); step(0, 0, 0);
    for (int i = 0; i < 600; i++)
      step(1'($urandom % 3 == 0), 1'($urandom % 2), 8'($urandom));
    step(0, 0, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule